// File: doc/BRIEF.md
# Prefetching Byte Queue with Sticky Fault Flags

This block is a power-of-two-deep byte queue that sits between a serial engine, which pushes received or outgoing bytes, and a processor-side port that drains them. The oldest stored byte is always present on a registered output. A consumer can therefore read it in the same cycle it decides to consume it. A separate advance strobe then retires that byte and brings the next one forward.

Beside the data, the block reports whether any byte is waiting and how many bytes are stored. It also keeps two fault flags. One records a push that was lost because the queue was full. The other records an advance attempted while the queue was empty. Both flags stay set until software-side logic clears them. There are two clear inputs. One wipes the contents and the flags. The other clears only the flags and leaves the buffered bytes in place.

Top module: `byte_fifo_sticky`

## Requirements
- R1: After synchronous reset, the count is 0, the ready flag is low, the head byte is 0 and both fault flags are low.
- R2: One cycle after a byte is accepted into an empty queue, it appears on the head output without any advance strobe. Each accepted advance presents the next byte on the following cycle, in the order the bytes were pushed.
- R3: The ready flag is high exactly when the count is non-zero.
- R4: The count equals the number of stored bytes, and never exceeds 2^ADDR_W. A push and an advance in the same cycle on a queue that is neither empty nor full leave the count unchanged.
- R5: A push into a full queue with no advance in the same cycle is dropped. The count stays at 2^ADDR_W, the stored bytes are unchanged, and the overflow flag is set on the next cycle.
- R6: A push into a full queue together with an advance in the same cycle is accepted. The count stays at 2^ADDR_W and no overflow is flagged.
- R7: An advance on an empty queue sets the underflow flag. The head output reads 0 whenever the count is 0.
- R8: The full clear empties the queue and lowers both fault flags on the next cycle. A push or advance in that same cycle is ignored.
- R9: The flags-only clear lowers both fault flags and leaves the count and the stored bytes unchanged. If a new fault occurs in the same cycle, that fault's flag is set.
- R10: A fault flag, once set, stays high until reset, the full clear, or the flags-only clear.
- R11: A push together with an advance on an empty queue stores the pushed byte: the count becomes 1 and the head shows that byte. The underflow flag is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push the byte on wr_byte |
| wr_byte | input | DATA_W | Byte to push |
| rd_next | input | 1 | Retire the head byte |
| clr_all | input | 1 | Empty the queue and clear the fault flags |
| clr_flags | input | 1 | Clear the fault flags only |
| head_byte | output | DATA_W | Oldest stored byte, 0 when empty |
| data_ready | output | 1 | At least one byte stored |
| byte_count | output | ADDR_W+1 | Number of stored bytes |
| ovf_flag | output | 1 | Sticky: a push was lost |
| unf_flag | output | 1 | Sticky: an advance hit an empty queue |

## Verification
A pointer or count that drifts shows up one cycle later as a wrong byte_count. It can also show up as a head byte out of push order, or as a lost or duplicated byte at the next advance. A flag register that forgets, or sets itself, differs from the expected value on the very next cycle. A full- or empty-detection error appears exactly at the boundary push or advance, either as a missing overflow/underflow flag or as a count that steps past 2^ADDR_W. Because every output is registered, each of these faults is visible on the cycle right after the edge that caused it.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  typedef struct packed {
    logic ovf;
    logic unf;
  } fault_t;
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_next,
  input  logic              clr_all,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] head_q,
  output logic              ready_q,
  output logic [ADDR_W:0]   count_q,
  output fault_t            fault
);
  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(1 << ADDR_W);

  logic [ADDR_W-1:0] rd_ptr_q, wr_ptr_q, rd_ptr_n, wr_ptr_n;
  logic [CW-1:0]     count_n, after_rd;
  logic              rd_ok, wr_ok;
  logic [DATA_W-1:0] head_n;

  always_comb begin
    rd_ok    = rd_next && (count_q != '0) && !clr_all;
    wr_ok    = wr_en && ((count_q != FULL_CNT) || rd_ok) && !clr_all;
    fault.ovf = wr_en && !wr_ok && !clr_all;
    fault.unf = rd_next && (count_q == '0) && !clr_all;
    after_rd = count_q - CW'(rd_ok);
    count_n  = after_rd + CW'(wr_ok);
    rd_ptr_n = rd_ptr_q + ADDR_W'(rd_ok);
    wr_ptr_n = wr_ptr_q + ADDR_W'(wr_ok);
    if (clr_all) begin
      count_n  = '0;
      rd_ptr_n = '0;
      wr_ptr_n = '0;
    end
    if (count_n == '0)
      head_n = '0;
    else if (wr_ok && after_rd == '0)
      head_n = wr_byte;
    else
      head_n = mem_rdata;
  end

  assign mem_we    = wr_ok;
  assign mem_waddr = wr_ptr_q;
  assign mem_raddr = rd_ptr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ready_q  <= 1'b0;
      head_q   <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_n;
      wr_ptr_q <= wr_ptr_n;
      count_q  <= count_n;
      ready_q  <= (count_n != '0);
      head_q   <= head_n;
    end
  end
endmodule

// File: rtl/byte_fifo_flags.sv
module byte_fifo_flags
  import byte_fifo_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr_all,
  input  logic   clr_flags,
  input  fault_t fault,
  output logic   ovf_q,
  output logic   unf_q
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= (ovf_q && !clr_flags) || fault.ovf;
      unf_q <= (unf_q && !clr_flags) || fault.unf;
    end
  end
endmodule

// File: rtl/byte_fifo_sticky.sv
module byte_fifo_sticky
  import byte_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_next,
  input  logic              clr_all,
  input  logic              clr_flags,
  output logic [DATA_W-1:0] head_byte,
  output logic              data_ready,
  output logic [ADDR_W:0]   byte_count,
  output logic              ovf_flag,
  output logic              unf_flag
);
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  fault_t            fault;

  byte_fifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_byte),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  byte_fifo_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_next(rd_next), .clr_all(clr_all),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .head_q(head_byte), .ready_q(data_ready),
    .count_q(byte_count), .fault(fault)
  );

  byte_fifo_flags u_flags (
    .clk(clk), .rst(rst), .clr_all(clr_all), .clr_flags(clr_flags),
    .fault(fault), .ovf_q(ovf_flag), .unf_q(unf_flag)
  );
endmodule

// File: rtl/fifo_sticky_chk.sv
module fifo_sticky_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_next,
  input logic              clr_all,
  input logic              clr_flags,
  input logic [DATA_W-1:0] head_byte,
  input logic              data_ready,
  input logic [ADDR_W:0]   byte_count,
  input logic              ovf_flag,
  input logic              unf_flag
);
  localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(1 << ADDR_W);

  assert_ready_R3: assert property (@(posedge clk) disable iff (rst)
    data_ready == (byte_count != '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    byte_count <= FULL_CNT);

  assert_steady_count_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_next && !clr_all && byte_count != '0 && byte_count != FULL_CNT)
    |=> $stable(byte_count));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_next && !clr_all && byte_count == FULL_CNT)
    |=> (ovf_flag && byte_count == FULL_CNT));

  assert_empty_head_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_count == '0) |-> (head_byte == '0));

  assert_full_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (byte_count == '0 && !ovf_flag && !unf_flag));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr_all && !clr_flags) |=> ovf_flag);

  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (unf_flag && !clr_all && !clr_flags) |=> unf_flag);
endmodule

bind byte_fifo_sticky fifo_sticky_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_next(rd_next),
  .clr_all(clr_all), .clr_flags(clr_flags), .head_byte(head_byte),
  .data_ready(data_ready), .byte_count(byte_count),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/sim_byte_fifo_sticky.sv
`timescale 1ns/1ps
module sim_byte_fifo_sticky;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_next = 1'b0, clr_all = 1'b0, clr_flags = 1'b0;
  logic [DATA_W-1:0] wr_byte = '0;
  logic [DATA_W-1:0] head_byte;
  logic data_ready, ovf_flag, unf_flag;
  logic [ADDR_W:0] byte_count;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] q[$];
  bit m_ovf = 1'b0, m_unf = 1'b0;

  always #2.5 clk = ~clk;

  byte_fifo_sticky #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .rd_next(rd_next),
    .clr_all(clr_all), .clr_flags(clr_flags), .head_byte(head_byte),
    .data_ready(data_ready), .byte_count(byte_count),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit rd_ok, wr_ok;
    if (rst || clr_all) begin
      q.delete();
      m_ovf = 0;
      m_unf = 0;
    end else begin
      rd_ok = rd_next && q.size() > 0;
      wr_ok = wr_en && (q.size() < DEPTH || rd_ok);
      if (clr_flags) begin
        m_ovf = 0;
        m_unf = 0;
      end
      if (wr_en && !wr_ok) m_ovf = 1;
      if (rd_next && q.size() == 0) m_unf = 1;
      if (rd_ok) void'(q.pop_front());
      if (wr_ok) q.push_back(wr_byte);
    end
  endtask

  task automatic compare(string tag);
    int exp_head;
    exp_head = (q.size() > 0) ? int'(q[0]) : 0;
    chk(tag, "byte_count", int'(byte_count), q.size());
    chk(tag, "data_ready", int'(data_ready), int'(q.size() > 0));
    chk(tag, "head_byte", int'(head_byte), exp_head);
    chk(tag, "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk(tag, "unf_flag", int'(unf_flag), int'(m_unf));
  endtask

  // Called at a falling edge: drive, take one rising edge, compare after it.
  task automatic step(bit w, logic [DATA_W-1:0] d, bit r, bit ca, bit cf, string tag);
    wr_en = w; wr_byte = d; rd_next = r; clr_all = ca; clr_flags = cf;
    @(posedge clk);
    model_update();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, "R1");
    // R2/R3: head visible without strobe, order preserved
    step(1, 8'h11, 0, 0, 0, "R2");
    step(1, 8'h22, 0, 0, 0, "R2");
    step(1, 8'h33, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R2");
    // R4: mid-level simultaneous push/advance keeps count
    step(1, 8'h44, 1, 0, 0, "R4");
    step(1, 8'h55, 1, 0, 0, "R4");
    // fill to full
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h80 + i), 0, 0, 0, "R4");
    // R5: push into full dropped
    step(1, 8'hEE, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R10");
    // R6: push plus advance at full accepted
    step(1, 8'hA6, 1, 0, 0, "R6");
    // R9: flags-only clear keeps data
    step(0, 0, 0, 0, 1, "R9");
    // R9: clear with concurrent fault sets flag
    step(1, 8'hEF, 0, 0, 1, "R9");
    // drain everything, watching order
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, "R2");
    // R7: advance on empty
    step(0, 0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    // R11: push plus advance on empty
    step(0, 0, 0, 0, 1, "R9");
    step(1, 8'h5A, 1, 0, 0, "R11");
    step(1, 8'h6B, 0, 0, 0, "R4");
    // R8: full clear ignores same-cycle push/advance
    step(1, 8'h7C, 1, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 60, 8'($urandom), (r % 3) == 0, r == 97, r == 98, "MIX");
    end
    // reset mid-run
    step(1, 8'h12, 0, 0, 0, "R1");
    rst = 1'b1;
    step(1, 8'h13, 1, 0, 0, "R1");
    rst = 1'b0;
    step(0, 0, 0, 0, 0, "R1");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule